// File: doc/BRIEF.md
# Multichannel Zero-Run Detector

The block watches the sample words of six audio channels that arrive side by side with one shared sample strobe. For each channel it counts how many strobed samples in a row were exactly zero. Once that count reaches the run length (1024 samples by default), the channel's flag becomes active and stays active until a nonzero sample arrives on that channel. A global flag is active only while every channel flag is active.

One control input selects the output polarity for all seven flags. The detector looks at the sample words given to it and nothing else. A datapath that copies one channel pair onto the others after this point therefore leaves the flags tied to the original streams. Muting, volume and pairing of left and right flags into stereo flags are left to logic outside the block.

Top module: `zero_run_detector`

## Requirements
- R1: A channel's flag becomes active right after the clock edge that takes the 1024th consecutive strobed zero sample on that channel, and not after 1023.
- R2: The global flag is active exactly when all six channel flags are active.
- R3: A strobed sample with any bit set, including only the most significant bit, restarts that channel's run and makes its flag inactive right after that edge. Other channels are not affected.
- R4: The run count saturates at the run length, so a zero run of any length (2048 samples or more) keeps the flag active.
- R5: With `flag_invert` at 0, active flags read 1. With `flag_invert` at 1, active flags read 0. The change applies to all seven outputs in the same cycle.
- R6: Clock edges with `smp_valid` low leave every run count unchanged, whatever `smp_data` holds.
- R7: A synchronous reset (`rst_n` low at a clock edge) clears every run count. The flags then read inactive in the selected polarity.
- R8: Channel c takes its sample from `smp_data[c*24 +: 24]` (channel 0 in the least significant bits), and each channel counts only its own slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Sample strobe shared by all channels |
| smp_data | input | 144 | Six 24-bit samples, channel c at bits c*24 +: 24 |
| flag_invert | input | 1 | 0 = active-high flags, 1 = active-low flags |
| chan_zero_o | output | 6 | Per-channel zero-run flags, bit c for channel c |
| all_zero_o | output | 1 | Global flag, active when all channels are in a zero run |

## Verification
The bench lands exactly on the threshold. It drives 1023 zeros and then one more, so an off-by-one compare either flags one sample early or one sample late. It pushes channels well past 2048 consecutive zeros, where a counter that wraps instead of saturating would silently drop the flag. It breaks runs with a sample whose only set bit is the channel's top bit and uses zero and nonzero masks that interleave channels, which exposes a zero test that ignores some bits or a slice taken at the wrong offset. It also holds nonzero data with the strobe low, flips polarity while flags are set, and resets in the middle of a run, which catches counting without a strobe, a global flag that does not follow the polarity, and counts that survive reset.

// File: rtl/zrd_pkg.sv
// Package: shared helpers for the zero-run detector.
// Assumes run lengths of at least one sample.
package zrd_pkg;

    // Output polarity selection carried on flag_invert.
    typedef enum logic {
        ZRD_POL_HIGH = 1'b0,
        ZRD_POL_LOW  = 1'b1
    } zrd_pol_e;

    // Width of a counter that must be able to hold the value run_len.
    function automatic int run_cnt_w(input int run_len);
        return $clog2(run_len + 1);
    endfunction

endpackage

// File: rtl/zrd_lane.sv
// Module: zrd_lane
// Counts consecutive strobed zero samples for one channel. The count
// saturates at RUN_LEN, and run_done is high while the count sits there.
// Assumes RUN_LEN >= 1. A strobed nonzero sample restarts the count.
module zrd_lane #(
    parameter int SAMPLE_W = 24,
    parameter int RUN_LEN  = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp,
    output logic                run_done
);
    localparam int             CNT_W   = zrd_pkg::run_cnt_w(RUN_LEN);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN);

    logic [CNT_W-1:0] cnt_q;
    logic             smp_is_zero;
    logic             at_max;

    // Zero test over every bit of the slice.
    assign smp_is_zero = (smp == '0);
    assign at_max      = (cnt_q == CNT_MAX);

    // Run counter: clear on reset or nonzero, hold at the maximum, step on zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (smp_valid) begin
            if (!smp_is_zero) begin
                cnt_q <= '0;
            end else if (!at_max) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // The run is complete while the counter sits at its ceiling.
    assign run_done = at_max;

endmodule

// File: rtl/zrd_out_stage.sv
// Module: zrd_out_stage
// Builds the global flag from the per-channel run results and applies the
// selected output polarity to all flags. Purely combinational, so a polarity
// change shows in the same cycle. Assumes run_done is active high.
module zrd_out_stage #(
    parameter int NUM_CH = 6
) (
    input  logic [NUM_CH-1:0] run_done,
    input  logic              pol_low,
    output logic [NUM_CH-1:0] chan_flag,
    output logic              all_flag
);
    zrd_pkg::zrd_pol_e pol;
    logic              all_done;

    // Decode the polarity control into its enum.
    assign pol = zrd_pkg::zrd_pol_e'(pol_low);

    // Global result is taken from the active-high results, before inversion.
    assign all_done = &run_done;

    // Polarity application for channel flags and the global flag.
    always_comb begin
        if (pol == zrd_pkg::ZRD_POL_LOW) begin
            chan_flag = ~run_done;
            all_flag  = ~all_done;
        end else begin
            chan_flag = run_done;
            all_flag  = all_done;
        end
    end

endmodule

// File: rtl/zero_run_detector.sv
// Module: zero_run_detector (top)
// Per-channel zero-run detection over NUM_CH parallel sample words with a
// shared strobe, plus a global all-channel flag with selectable polarity.
// Assumes samples are valid whenever smp_valid is high at a clock edge.
// Channel c occupies smp_data[c*SAMPLE_W +: SAMPLE_W].
module zero_run_detector #(
    parameter int NUM_CH   = 6,
    parameter int SAMPLE_W = 24,
    parameter int RUN_LEN  = 1024
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0] smp_data,
    input  logic                       flag_invert,
    output logic [NUM_CH-1:0]          chan_zero_o,
    output logic                       all_zero_o
);
    logic [NUM_CH-1:0] run_done;

    // One counting lane per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
        zrd_lane #(
            .SAMPLE_W (SAMPLE_W),
            .RUN_LEN  (RUN_LEN)
        ) i_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .smp_valid (smp_valid),
            .smp       (smp_data[c*SAMPLE_W +: SAMPLE_W]),
            .run_done  (run_done[c])
        );
    end

    // Global flag and polarity stage.
    zrd_out_stage #(
        .NUM_CH (NUM_CH)
    ) i_out (
        .run_done  (run_done),
        .pol_low   (flag_invert),
        .chan_flag (chan_zero_o),
        .all_flag  (all_zero_o)
    );

endmodule

// File: rtl/zrd_checker.sv
// Module: zrd_checker
// Port-level properties of zero_run_detector, bound to every instance.
// Works on polarity-corrected flags so the checks hold for both polarities.
module zrd_checker #(
    parameter int NUM_CH   = 6,
    parameter int SAMPLE_W = 24
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       smp_valid,
    input logic [NUM_CH*SAMPLE_W-1:0] smp_data,
    input logic                       flag_invert,
    input logic [NUM_CH-1:0]          chan_zero_o,
    input logic                       all_zero_o
);
    logic [NUM_CH-1:0] act;
    logic              all_act;

    // Active-high view of the outputs.
    assign act     = chan_zero_o ^ {NUM_CH{flag_invert}};
    assign all_act = all_zero_o ^ flag_invert;

    AST_GLOBAL_IS_AND: assert property (@(posedge clk) disable iff (!rst_n)
        all_act == (&act)) else $error("global flag mismatch"); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> $stable(act)) else $error("flags moved without strobe"); // R6

    AST_RESET_INACTIVE: assert property (@(posedge clk)
        !rst_n |=> (act == '0 && !all_act)) else $error("flag active after reset"); // R7

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        AST_NONZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_valid && smp_data[c*SAMPLE_W +: SAMPLE_W] != '0) |=> !act[c])
            else $error("flag survived nonzero sample"); // R3

        AST_RISE_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(act[c]) |-> ($past(smp_valid) && $past(smp_data[c*SAMPLE_W +: SAMPLE_W]) == '0))
            else $error("flag rose without zero sample"); // R1
    end

endmodule

bind zero_run_detector zrd_checker #(
    .NUM_CH   (NUM_CH),
    .SAMPLE_W (SAMPLE_W)
) i_zrd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid   (smp_valid),
    .smp_data    (smp_data),
    .flag_invert (flag_invert),
    .chan_zero_o (chan_zero_o),
    .all_zero_o  (all_zero_o)
);

// File: tb/test_zero_run_detector.sv
// Bench for zero_run_detector: a vector table walked by one loop, then
// directed tests for reset, strobe gating, polarity and saturation.
module test_zero_run_detector;
    localparam int NCH = 6;
    localparam int W   = 24;
    localparam int NV  = 8;

    // Vector: {zero mask[24:19], strobes[18:7], expected flags[6:1], expected global[0]}
    localparam logic [24:0] VEC [NV] = '{
        {6'h3F, 12'd1023, 6'h00, 1'b0},  // R1: one short of the run
        {6'h3F, 12'd1,    6'h3F, 1'b1},  // R1 R2: threshold reached
        {6'h3E, 12'd1,    6'h3E, 1'b0},  // R3: channel 0 breaks its run
        {6'h3F, 12'd1023, 6'h3E, 1'b0},  // R4: others pass 2048 zeros
        {6'h3F, 12'd1,    6'h3F, 1'b1},  // R1 R4: channel 0 back, all held
        {6'h00, 12'd1,    6'h00, 1'b0},  // R3: every channel nonzero
        {6'h15, 12'd1024, 6'h15, 1'b0},  // R8: alternating channels
        {6'h2A, 12'd1,    6'h00, 1'b0}   // R3 R8: swap the mask
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 smp_valid = 1'b0;
    logic [NCH*W-1:0]     smp_data = '0;
    logic                 flag_invert = 1'b0;
    logic [NCH-1:0]       chan_zero_o;
    logic                 all_zero_o;
    int                   n_run = 0;
    int                   n_fail = 0;
    bit                   done = 1'b0;

    always #4 clk = ~clk;

    zero_run_detector i_zero_run_detector (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid   (smp_valid),
        .smp_data    (smp_data),
        .flag_invert (flag_invert),
        .chan_zero_o (chan_zero_o),
        .all_zero_o  (all_zero_o)
    );

    // Zero for channels in the mask, a single set bit elsewhere (channel 5 gets the MSB).
    function automatic logic [NCH*W-1:0] build(input logic [NCH-1:0] zmask);
        logic [NCH*W-1:0] v = '0;
        for (int c = 0; c < NCH; c++)
            if (!zmask[c]) v[c*W + c*4 + 3] = 1'b1;
        return v;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Apply n strobed samples, then drop the strobe; outputs settle on the last edge.
    task automatic drive(input logic [NCH-1:0] zmask, input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_data  = build(zmask);
        end
        @(negedge clk);
        smp_valid = 1'b0;
        #1;
    endtask

    initial begin
        // R7: reset state in both polarities.
        repeat (3) @(negedge clk);
        #1;
        check("R7 reset flags high-pol", 8'(chan_zero_o), 8'h00);
        check("R7 reset global high-pol", 8'(all_zero_o), 8'h0);
        flag_invert = 1'b1;
        #1;
        check("R7 R5 reset flags low-pol", 8'(chan_zero_o), 8'h3F);
        check("R7 R5 reset global low-pol", 8'(all_zero_o), 8'h1);
        flag_invert = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // Table walk.
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][24:19], int'(VEC[i][18:7]));
            check($sformatf("R1 R2 R3 R4 R8 entry %0d flags", i), 8'(chan_zero_o), 8'(VEC[i][6:1]));
            check($sformatf("R2 entry %0d global", i), 8'(all_zero_o), 8'(VEC[i][0]));
        end

        // R1: full run from mixed counts.
        drive(6'h3F, 1024);
        check("R1 full run flags", 8'(chan_zero_o), 8'h3F);
        check("R2 full run global", 8'(all_zero_o), 8'h1);

        // R6: nonzero data without strobe is ignored.
        smp_data = build(6'h00);
        repeat (5) @(negedge clk);
        #1;
        check("R6 no strobe flags", 8'(chan_zero_o), 8'h3F);
        check("R6 no strobe global", 8'(all_zero_o), 8'h1);

        // R5: polarity flip takes effect in the same cycle.
        flag_invert = 1'b1;
        #1;
        check("R5 inverted flags", 8'(chan_zero_o), 8'h00);
        check("R5 inverted global", 8'(all_zero_o), 8'h0);
        flag_invert = 1'b0;
        #1;

        // R3: only the MSB of channel 5 set.
        drive(6'h1F, 1);
        check("R3 msb-only flags", 8'(chan_zero_o), 8'h1F);
        check("R3 msb-only global", 8'(all_zero_o), 8'h0);

        // R7: reset in the middle of a run.
        drive(6'h3F, 1000);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R7 mid-run reset flags", 8'(chan_zero_o), 8'h00);
        drive(6'h3F, 1000);
        check("R7 R1 count restarted", 8'(chan_zero_o), 8'h00);
        drive(6'h3F, 24);
        check("R1 post-reset run flags", 8'(chan_zero_o), 8'h3F);
        check("R2 post-reset run global", 8'(all_zero_o), 8'h1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule